// File: doc/BRIEF.md
# Debug Bus Access Comparator Bank

This block watches a CPU bus for an on-chip debug unit. Every clock it takes in one observed bus cycle: a valid flag, the issued address, direction, access size, an opcode-fetch flag and a data word with its own valid flag. It compares that cycle against a small set of programmed comparator channels and raises one registered match pulse per channel. The channels are not all equally capable. Channel 0 qualifies on address, direction, access size and data. Channel 1 qualifies on address, direction and access size. Channel 2 qualifies on address and direction only. Qualifier bits that a channel does not support have no effect on it.

Matching uses the exact address put on the bus. A word access issued one byte below the target touches the target byte, but it does not count as a hit. In opcode-fetch mode a channel compares against the address with bit 0 cleared. A fetch at an odd address therefore hits a comparator that holds the even address just below it. Each bus cycle is judged on its own, and no state carries over from one hit to the next.

Settings are loaded through a plain write port. There is no readback. The bus side only observes and has no ready signal. The block can never stall or back-pressure the bus, and every cycle with `bus_valid` high is evaluated.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset every channel is disabled and its address, data and control fields are zero. No match pulse appears until a channel's enable bit has been written.
- R2: `match[i]` is high for exactly the one cycle after a qualifying cycle with `bus_valid` high. It only rises if the enable bit of channel i (control bit 0) was set when that cycle was sampled. Output index 0, 1 and 2 belongs to channel 0, 1 and 2.
- R3: With fetch mode off, a channel hits only when `bus_fetch` is 0 and `bus_addr` equals its programmed address exactly. A word access at n-1 does not hit a comparator holding n.
- R4: With direction enable (control bit 1) clear, reads and writes both hit. With it set, only cycles whose `bus_rd` equals control bit 2 hit (1 = read).
- R5: On channels 0 and 1, size enable (control bit 3) set means only byte accesses hit if control bit 4 is 1, and only word accesses (`bus_word`=1) hit if it is 0. Clear means either size hits. Channel 2 ignores bits 3 and 4.
- R6: On channel 0, data enable (control bit 5) set requires `bus_dvalid`=1 and equal data under a mask. The mask is all 16 bits for a word and bits [7:0] for a byte, so bits [15:8] of a byte access are ignored. Channels 1 and 2 ignore bit 5.
- R7: With fetch mode (control bit 6) set, a channel hits only on cycles with `bus_fetch`=1 whose address, with bit 0 cleared, equals the programmed address. Direction, size and data qualifiers are not applied in this mode. With bit 6 clear, fetch cycles never hit.
- R8: Each bus cycle is compared on its own. A hit followed by a non-qualifying cycle gives a pulse and then low, and repeated qualifying cycles give back-to-back pulses.
- R9: A write with `cfg_we` selects a channel with `cfg_sel` and a field with `cfg_field`: 0 control, 1 address, 2 compare data. The new value governs bus cycles from the next clock on. A bus cycle sampled in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | SW | Channel index for the write |
| cfg_field | input | 2 | Field: 0 control, 1 address, 2 data |
| cfg_wdata | input | WW | Write value |
| bus_valid | input | 1 | Observed bus cycle present |
| bus_addr | input | AW | Issued bus address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_fetch | input | 1 | Cycle is an opcode fetch |
| bus_dvalid | input | 1 | Data bus holds valid data |
| bus_data | input | DW | Bus data, byte lane in bits [7:0] |
| match | output | NCH | Registered match pulse per channel |

## Verification
The bench aims at the overlap trap: a word access at n-1 against a comparator on n must stay silent. A design that matched on the touched byte range would pulse there. It also pits a byte-only setting against a word access and gives the address-only channel size bits it must ignore. A design that wired capabilities to the wrong channel would then miss or add pulses. Odd-address fetches against an even comparator catch a missing bit-0 clear, and byte accesses with junk in the upper lane catch an unmasked data compare. A settings write in the same cycle as a matching bus cycle shows whether the new value leaks into that cycle. Constrained random traffic over a narrow address and data pool keeps hits frequent.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

  // Channel control word, bit 0 = en ... bit 6 = fetch
  typedef struct packed {
    logic fetch;    // bit 6: opcode-fetch mode, even-aligned compare
    logic den;      // bit 5: data qualification
    logic byte_sz;  // bit 4: 1 = byte only, 0 = word only (with sze)
    logic sze;      // bit 3: size qualification
    logic rd;       // bit 2: wanted direction, 1 = read
    logic rwe;      // bit 1: direction qualification
    logic en;       // bit 0: channel enable
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] FLD_CTRL = 2'd0;
  localparam logic [1:0] FLD_ADDR = 2'd1;
  localparam logic [1:0] FLD_DATA = 2'd2;

endpackage

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
  import dbg_cmp_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int SW  = 2,
  parameter int WW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [1:0]    field,
  input  logic [WW-1:0] wdata,
  output ctrl_t         ctrl_o [NCH],
  output logic [AW-1:0] addr_o [NCH],
  output logic [DW-1:0] data_o [NCH]
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_sel;
    assign hit_sel = we && (sel == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_o[i] <= '0;
        addr_o[i] <= '0;
        data_o[i] <= '0;
      end else if (hit_sel) begin
        case (field)
          FLD_CTRL: ctrl_o[i] <= ctrl_t'(wdata[CTRL_W-1:0]);
          FLD_ADDR: addr_o[i] <= wdata[AW-1:0];
          FLD_DATA: data_o[i] <= wdata[DW-1:0];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dbg_cmp_chan.sv
module dbg_cmp_chan
  import dbg_cmp_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter bit HAS_SIZE = 1'b0,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] caddr,
  input  logic [DW-1:0] cdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_word,
  input  logic          bus_fetch,
  input  logic          bus_dvalid,
  input  logic [DW-1:0] bus_data,
  output logic          match_q
);

  localparam logic [DW-1:0] BYTE_MASK = {{(DW-8){1'b0}}, 8'hFF};

  logic dir_ok, size_ok, data_ok, fetch_hit, access_hit, hit;

  assign dir_ok = !ctrl.rwe || (bus_rd == ctrl.rd);

  if (HAS_SIZE) begin : g_size
    assign size_ok = !ctrl.sze || (bus_word != ctrl.byte_sz);
  end else begin : g_nosize
    assign size_ok = 1'b1;
  end

  if (HAS_DATA) begin : g_data
    logic [DW-1:0] lane_mask;
    assign lane_mask = bus_word ? {DW{1'b1}} : BYTE_MASK;
    assign data_ok = !ctrl.den ||
                     (bus_dvalid && (((bus_data ^ cdata) & lane_mask) == '0));
  end else begin : g_nodata
    assign data_ok = 1'b1;
  end

  assign fetch_hit  = bus_fetch && ({bus_addr[AW-1:1], 1'b0} == caddr);
  assign access_hit = !bus_fetch && (bus_addr == caddr) &&
                      dir_ok && size_ok && data_ok;

  always_comb begin
    if (ctrl.fetch) hit = fetch_hit;
    else            hit = access_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= bus_valid && ctrl.en && hit;
  end

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int             NCH       = 3,
  parameter int             AW        = 16,
  parameter int             DW        = 16,
  parameter logic [NCH-1:0] SIZE_CAPS = 3'b011,
  parameter logic [NCH-1:0] DATA_CAPS = 3'b001,
  localparam int            SW        = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int            WA        = (AW > DW) ? AW : DW,
  localparam int            WW        = (WA > CTRL_W) ? WA : CTRL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_sel,
  input  logic [1:0]     cfg_field,
  input  logic [WW-1:0]  cfg_wdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_rd,
  input  logic           bus_word,
  input  logic           bus_fetch,
  input  logic           bus_dvalid,
  input  logic [DW-1:0]  bus_data,
  output logic [NCH-1:0] match
);

  ctrl_t         ctrl_arr [NCH];
  logic [AW-1:0] addr_arr [NCH];
  logic [DW-1:0] data_arr [NCH];

  dbg_cmp_regs #(
    .NCH(NCH), .AW(AW), .DW(DW), .SW(SW), .WW(WW)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .field (cfg_field),
    .wdata (cfg_wdata),
    .ctrl_o(ctrl_arr),
    .addr_o(addr_arr),
    .data_o(data_arr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dbg_cmp_chan #(
      .AW(AW), .DW(DW),
      .HAS_SIZE(SIZE_CAPS[i]),
      .HAS_DATA(DATA_CAPS[i])
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl      (ctrl_arr[i]),
      .caddr     (addr_arr[i]),
      .cdata     (data_arr[i]),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_word  (bus_word),
      .bus_fetch (bus_fetch),
      .bus_dvalid(bus_dvalid),
      .bus_data  (bus_data),
      .match_q   (match[i])
    );
  end

  // Observation points for the bound checker
  logic [NCH-1:0] en_vec;
  ctrl_t          ctl_b, ctl_c;
  logic [AW-1:0]  adr_b;

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign en_vec[i] = ctrl_arr[i].en;
  end
  assign ctl_b = ctrl_arr[1];
  assign ctl_c = ctrl_arr[2];
  assign adr_b = addr_arr[1];

endmodule

// File: rtl/dbg_cmp_bank_chk.sv
module dbg_cmp_bank_chk
  import dbg_cmp_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_valid,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_rd,
  input logic           bus_word,
  input logic           bus_fetch,
  input logic [NCH-1:0] match,
  input logic [NCH-1:0] en_vec,
  input ctrl_t          ctl_b,
  input ctrl_t          ctl_c,
  input logic [AW-1:0]  adr_b
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (match == '0));

  a_r2_needs_bus_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> $past(bus_valid));

  for (genvar i = 0; i < NCH; i++) begin : g_en
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |-> $past(en_vec[i]));
  end

  a_r3_exact_addr_b: assert property (@(posedge clk) disable iff (!rst_n)
    (match[1] && !$past(ctl_b.fetch)) |-> ($past(bus_addr) == $past(adr_b)));

  a_r4_dir_c: assert property (@(posedge clk) disable iff (!rst_n)
    (match[2] && $past(ctl_c.rwe) && !$past(ctl_c.fetch))
      |-> ($past(bus_rd) == $past(ctl_c.rd)));

  a_r5_size_b: assert property (@(posedge clk) disable iff (!rst_n)
    (match[1] && $past(ctl_b.sze) && !$past(ctl_b.fetch))
      |-> ($past(bus_word) == !$past(ctl_b.byte_sz)));

  a_r7_fetch_only_b: assert property (@(posedge clk) disable iff (!rst_n)
    (match[1] && $past(ctl_b.fetch)) |-> $past(bus_fetch));

endmodule

bind dbg_cmp_bank dbg_cmp_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_word (bus_word),
  .bus_fetch(bus_fetch),
  .match    (match),
  .en_vec   (en_vec),
  .ctl_b    (ctl_b),
  .ctl_c    (ctl_c),
  .adr_b    (adr_b)
);

// File: tb/sim_dbg_cmp_bank.sv
module sim_dbg_cmp_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [1:0]  cfg_field = '0;
  logic [15:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_word = 1'b0;
  logic        bus_fetch = 1'b0;
  logic        bus_dvalid = 1'b0;
  logic [15:0] bus_data = '0;
  logic [2:0]  match;

  dbg_cmp_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_fetch(bus_fetch), .bus_dvalid(bus_dvalid), .bus_data(bus_data),
    .match(match)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference model of the settings
  logic [6:0]  m_ctrl [3];
  logic [15:0] m_addr [3];
  logic [15:0] m_data [3];
  logic [2:0]  exp_q = '0;

  function automatic bit model_hit(int ch, bit v, logic [15:0] a, bit rd,
                                   bit wd, bit f, bit dv, logic [15:0] d);
    bit has_size, has_data, ok;
    logic [6:0] c;
    logic [15:0] mask;
    c = m_ctrl[ch];
    has_size = (ch < 2);
    has_data = (ch == 0);
    if (!v || !c[0]) return 1'b0;
    if (c[6]) return f && ((a & 16'hFFFE) == m_addr[ch]);
    ok = !f && (a == m_addr[ch]);
    if (c[1] && (rd != c[2])) ok = 1'b0;
    if (has_size && c[3] && (wd == c[4])) ok = 1'b0;
    mask = wd ? 16'hFFFF : 16'h00FF;
    if (has_data && c[5] && !(dv && (((d ^ m_data[ch]) & mask) == 16'h0)))
      ok = 1'b0;
    return ok;
  endfunction

  task automatic check_out();
    for (int ch = 0; ch < 3; ch++) begin
      checks++;
      if (match[ch] !== exp_q[ch]) begin
        errors++;
        $display("FAIL %s ch%0d match actual %b expected %b at %0t",
                 cur_req, ch, match[ch], exp_q[ch], $time);
      end
    end
  endtask

  // one clock: check previous result, apply new inputs, predict
  task automatic step(bit we, int sel, int fld, logic [15:0] wv, bit v,
                      logic [15:0] a, bit rd, bit wd, bit f, bit dv,
                      logic [15:0] d);
    @(negedge clk);
    check_out();
    cfg_we = we; cfg_sel = 2'(sel); cfg_field = 2'(fld); cfg_wdata = wv;
    bus_valid = v; bus_addr = a; bus_rd = rd; bus_word = wd;
    bus_fetch = f; bus_dvalid = dv; bus_data = d;
    for (int ch = 0; ch < 3; ch++) exp_q[ch] = model_hit(ch, v, a, rd, wd, f, dv, d);
    if (we && sel < 3) begin
      case (fld)
        0: m_ctrl[sel] = wv[6:0];
        1: m_addr[sel] = wv;
        2: m_data[sel] = wv;
        default: ;
      endcase
    end
  endtask

  task automatic wr(int sel, int fld, logic [15:0] wv);
    step(1'b1, sel, fld, wv, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic bus(logic [15:0] a, bit rd, bit wd, bit f, bit dv, logic [15:0] d);
    step(1'b0, 0, 0, 16'h0, 1'b1, a, rd, wd, f, dv, d);
  endtask

  task automatic idle();
    step(1'b0, 0, 0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic clear_all();
    for (int ch = 0; ch < 3; ch++) wr(ch, 0, 16'h0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int ch = 0; ch < 3; ch++) begin
      m_ctrl[ch] = '0; m_addr[ch] = '0; m_data[ch] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values are zero, address 0 traffic must not hit
    cur_req = "R1";
    bus(16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    bus(16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0);
    idle();

    // R2: channel configured but disabled, then enabled
    cur_req = "R2";
    wr(2, 1, 16'h1234);
    bus(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    wr(2, 0, 16'h0001);
    bus(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b0, 0, 0, 16'h0, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R3: exact address, word at n-1 misses
    cur_req = "R3";
    wr(2, 1, 16'h2001);
    bus(16'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    bus(16'h2001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h2002, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R4: direction qualifier
    cur_req = "R4";
    wr(2, 0, 16'h0007);
    bus(16'h2001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h2001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    wr(2, 0, 16'h0003);
    bus(16'h2001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h2001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // R5: size on channel 1, ignored on channel 2
    cur_req = "R5";
    wr(1, 1, 16'h3000); wr(1, 0, 16'h0019);
    wr(2, 1, 16'h3000); wr(2, 0, 16'h0019);
    bus(16'h3000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h3000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    wr(1, 0, 16'h0009);
    bus(16'h3000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    bus(16'h3000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    clear_all();

    // R6: data qualifier with byte lane masking on channel 0
    cur_req = "R6";
    wr(0, 1, 16'h4000); wr(0, 2, 16'h12AB); wr(0, 0, 16'h0021);
    wr(1, 1, 16'h4000); wr(1, 2, 16'h5555); wr(1, 0, 16'h0021);
    bus(16'h4000, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFAB);
    bus(16'h4000, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFAB);
    bus(16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFAB);
    bus(16'h4000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h12AB);
    bus(16'h4000, 1'b0, 1'b0, 1'b0, 1'b1, 16'h12AC);
    clear_all();

    // R7: opcode fetch mode, even-aligned compare
    cur_req = "R7";
    wr(0, 1, 16'h5000); wr(0, 0, 16'h0041);
    wr(1, 1, 16'h5000); wr(1, 0, 16'h0001);
    bus(16'h5001, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    bus(16'h5000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    bus(16'h5000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h5002, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);

    // R8: independent per-cycle evaluation
    cur_req = "R8";
    bus(16'h5001, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    bus(16'h5001, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    bus(16'h6000, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    bus(16'h5001, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    clear_all();

    // R9: write and bus cycle in the same clock
    cur_req = "R9";
    wr(2, 1, 16'h7000);
    step(1'b1, 2, 0, 16'h0001, 1'b1, 16'h7000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h7000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b1, 2, 1, 16'h7002, 1'b1, 16'h7000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    bus(16'h7000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);

    // constrained random mix over all requirements
    cur_req = "R2-rand R3 R4 R5 R6 R7 R8";
    for (int it = 0; it < 4000; it++) begin
      if (($urandom % 6) == 0) begin
        int ch = int'($urandom % 3);
        int fld = int'($urandom % 3);
        logic [15:0] wv;
        if (fld == 0) wv = 16'($urandom % 128) | 16'h0001;
        else if (fld == 1) wv = 16'h1000 + 16'($urandom % 4);
        else wv = {(($urandom % 2) != 0) ? 8'hA5 : 8'h3C, 8'h10 + 8'($urandom % 2)};
        wr(ch, fld, wv);
      end else begin
        logic [15:0] a = 16'h1000 + 16'($urandom % 4);
        logic [15:0] d = {(($urandom % 2) != 0) ? 8'hA5 : 8'h3C, 8'h10 + 8'($urandom % 2)};
        step(1'b0, 0, 0, 16'h0, ($urandom % 8) != 0, a, 1'($urandom),
             1'($urandom), (($urandom % 4) == 0), 1'($urandom), d);
      end
    end
    idle();
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule